// File: doc/BRIEF.md
# Clock Source Control Register

This block holds a single 32-bit control word that governs three clock sources: an on-die RC oscillator, an external crystal oscillator and a main PLL. Software writes the word over a simple write-strobe bus and reads it back combinationally. The block drives the enable lines to the oscillator and PLL models and captures their stable or lock indications into read-only ready flags.

Hardware rules sit on top of the software value. Entering a low-power state clears the enables. Wake-up, an external-clock failure or use of the RC oscillator as the system clock force the RC enable on. The source feeding the system clock cannot be switched off by software. The bypass bit is locked while the external oscillator runs. The clock-security enable can only be set. Each oscillator's ready flag falls only after six ticks of that oscillator's own clock once its enable is gone. Each source clock is modelled as a one-cycle tick input sampled in the register clock domain.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset every field reads 0, and bits 31..9 always read 0. Bit map: 0 RC enable, 1 RC keep-in-stop, 2 RC ready, 3 external enable, 4 external ready, 5 bypass, 6 security enable, 7 PLL enable, 8 PLL ready.
- R2: Software reads and writes the RC enable (bit 0). A `lp_enter` pulse clears it. It is forced to 1 on the next edge by any of these: `stop_exit` with `wake_sel_a` or `wake_sel_b` high, `ext_fail`, or `sys_on_rc`. The forcing wins over both the write and `lp_enter`.
- R3: The keep-in-stop bit (bit 1) is software read/write and never changes bit 0. `rc_osc_en` = bit0 OR (bit1 AND `in_stop`).
- R4: The RC ready flag (bit 2) can become 1 only while bit 0 is 1. While bit 0 is 1, it takes the value of `rc_stable` one edge later.
- R5: Once bit 0 reads 0, a set RC ready flag stays 1 until the 6th `rc_tick` sampled after that point, and it clears on that edge. If bit 0 is set again, the count restarts.
- R6: Software reads and writes the external enable (bit 3). A software clear is ignored while `sys_on_ext` is 1. A `lp_enter` pulse clears it unconditionally.
- R7: The external ready flag (bit 4) follows R4 and R5 with bit 3, `ext_stable` and `ext_tick` in place of the RC signals.
- R8: A write to the bypass bit (bit 5) takes effect only if bit 3 was 0 before that write. Otherwise it is ignored. `ext_bypass` outputs bit 5.
- R9: Writing 1 to the security enable (bit 6) sets it. Writing 0 has no effect, and only reset clears it.
- R10: `clk_det_en` = bit 6 AND bit 4 AND NOT a failure flag. The failure flag is set by `ext_fail` and cleared on any edge where bit 3 was 0 and `ext_fail` is low.
- R11: Software reads and writes the PLL enable (bit 7). A software clear is ignored while `sys_on_pll` is 1. `lp_enter` clears it.
- R12: The PLL ready flag (bit 8) equals `pll_lock` from the previous edge.
- R13: Writes to bits 2, 4, 8 and 31..9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (current register value) |
| lp_enter | input | 1 | Pulse: entering a low-power state |
| in_stop | input | 1 | Level: Stop state active |
| stop_exit | input | 1 | Pulse: leaving Stop |
| wake_sel_a | input | 1 | Wake-up clock select, first input |
| wake_sel_b | input | 1 | Wake-up clock select, second input |
| ext_fail | input | 1 | Pulse: external clock failure detected |
| sys_on_rc | input | 1 | System clock derives from the RC oscillator |
| sys_on_ext | input | 1 | System clock derives from the external oscillator |
| sys_on_pll | input | 1 | System clock is the PLL |
| rc_stable | input | 1 | RC oscillator model reports stable |
| ext_stable | input | 1 | External oscillator model reports stable |
| pll_lock | input | 1 | PLL model reports lock |
| rc_tick | input | 1 | One-cycle tick per RC oscillator period |
| ext_tick | input | 1 | One-cycle tick per external oscillator period |
| rc_osc_en | output | 1 | Run request to the RC oscillator |
| ext_osc_en | output | 1 | Run request to the external oscillator |
| ext_bypass | output | 1 | Bypass select to the external oscillator |
| pll_en | output | 1 | Run request to the PLL |
| clk_det_en | output | 1 | Clock-detector enable |

## Verification
The assertions take all inputs to be synchronous to `clk` and stable between edges. They also assume `rc_tick` and `ext_tick` are single-cycle strobes, and that the three `sys_on_*` levels come from a multiplexer model rather than from the register itself. The stimulus drives every input shortly after the falling edge. It changes the `sys_on_*` levels only rarely and keeps the low-power, failure and wake-up pulses sparse. Write data is fully random, so every protection and lock rule is met under conflicting hardware events.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
    localparam int REG_W       = 32;
    localparam int DRAIN_TICKS = 6;

    localparam int B_RC_EN   = 0;
    localparam int B_RC_KEEP = 1;
    localparam int B_RC_RDY  = 2;
    localparam int B_EXT_EN  = 3;
    localparam int B_EXT_RDY = 4;
    localparam int B_BYP     = 5;
    localparam int B_SEC     = 6;
    localparam int B_PLL_EN  = 7;
    localparam int B_PLL_RDY = 8;
    localparam int USED_BITS = 9;

    typedef struct packed {
        logic rc_en;
        logic rc_keep;
        logic ext_en;
        logic byp;
        logic sec;
        logic pll_en;
        logic pll_rdy;
        logic fail;
    } ctl_t;
endpackage

// File: rtl/clk_rdy_tracker.sv
module clk_rdy_tracker #(
    parameter int DRAIN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stable,
    input  logic tick,
    output logic rdy
);
    localparam int CW = $clog2(DRAIN + 1);

    typedef struct packed {
        logic          rdy;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (en) begin
            trk_d.rdy = stable;
            trk_d.cnt = '0;
        end else if (trk_q.rdy) begin
            if (tick) begin
                if (trk_q.cnt == CW'(DRAIN - 1)) begin
                    trk_d.rdy = 1'b0;
                    trk_d.cnt = '0;
                end else begin
                    trk_d.cnt = trk_q.cnt + 1'b1;
                end
            end
        end else begin
            trk_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign rdy = trk_q.rdy;
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
    import clk_ctrl_pkg::*;
#(
    parameter int DRAIN = DRAIN_TICKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             lp_enter,
    input  logic             in_stop,
    input  logic             stop_exit,
    input  logic             wake_sel_a,
    input  logic             wake_sel_b,
    input  logic             ext_fail,
    input  logic             sys_on_rc,
    input  logic             sys_on_ext,
    input  logic             sys_on_pll,
    input  logic             rc_stable,
    input  logic             ext_stable,
    input  logic             pll_lock,
    input  logic             rc_tick,
    input  logic             ext_tick,
    output logic             rc_osc_en,
    output logic             ext_osc_en,
    output logic             ext_bypass,
    output logic             pll_en,
    output logic             clk_det_en
);
    ctl_t ctl_d, ctl_q;
    logic rc_rdy, ext_rdy;
    logic rc_force;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[REG_W-1:USED_BITS], reg_wdata[B_PLL_RDY],
                            reg_wdata[B_EXT_RDY], reg_wdata[B_RC_RDY]};

    assign rc_force = (stop_exit & (wake_sel_a | wake_sel_b)) | ext_fail | sys_on_rc;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            ctl_d.rc_en   = reg_wdata[B_RC_EN];
            ctl_d.rc_keep = reg_wdata[B_RC_KEEP];
            ctl_d.ext_en  = reg_wdata[B_EXT_EN] | (ctl_q.ext_en & sys_on_ext);
            ctl_d.pll_en  = reg_wdata[B_PLL_EN] | (ctl_q.pll_en & sys_on_pll);
            ctl_d.sec     = ctl_q.sec | reg_wdata[B_SEC];
            if (!ctl_q.ext_en) ctl_d.byp = reg_wdata[B_BYP];
        end
        if (lp_enter) begin
            ctl_d.rc_en  = 1'b0;
            ctl_d.ext_en = 1'b0;
            ctl_d.pll_en = 1'b0;
        end
        if (rc_force) ctl_d.rc_en = 1'b1;
        ctl_d.pll_rdy = pll_lock;
        if (ext_fail)          ctl_d.fail = 1'b1;
        else if (!ctl_q.ext_en) ctl_d.fail = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    clk_rdy_tracker #(.DRAIN(DRAIN)) u_rc_trk (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.rc_en),
        .stable(rc_stable), .tick(rc_tick), .rdy(rc_rdy)
    );

    clk_rdy_tracker #(.DRAIN(DRAIN)) u_ext_trk (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.ext_en),
        .stable(ext_stable), .tick(ext_tick), .rdy(ext_rdy)
    );

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[B_RC_EN]   = ctl_q.rc_en;
        reg_rdata[B_RC_KEEP] = ctl_q.rc_keep;
        reg_rdata[B_RC_RDY]  = rc_rdy;
        reg_rdata[B_EXT_EN]  = ctl_q.ext_en;
        reg_rdata[B_EXT_RDY] = ext_rdy;
        reg_rdata[B_BYP]     = ctl_q.byp;
        reg_rdata[B_SEC]     = ctl_q.sec;
        reg_rdata[B_PLL_EN]  = ctl_q.pll_en;
        reg_rdata[B_PLL_RDY] = ctl_q.pll_rdy;
    end

    assign rc_osc_en  = ctl_q.rc_en | (ctl_q.rc_keep & in_stop);
    assign ext_osc_en = ctl_q.ext_en;
    assign ext_bypass = ctl_q.byp;
    assign pll_en     = ctl_q.pll_en;
    assign clk_det_en = ctl_q.sec & ext_rdy & ~ctl_q.fail;
endmodule

// File: rtl/clk_ctrl_chk.sv
module clk_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        wr_sec,
    input logic [31:0] reg_rdata,
    input logic        lp_enter,
    input logic        in_stop,
    input logic        stop_exit,
    input logic        wake_sel_a,
    input logic        wake_sel_b,
    input logic        ext_fail,
    input logic        sys_on_rc,
    input logic        sys_on_ext,
    input logic        sys_on_pll,
    input logic        pll_lock,
    input logic        rc_tick,
    input logic        ext_tick,
    input logic        rc_osc_en,
    input logic        clk_det_en
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:9] == '0);

    p_force_rc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_exit && (wake_sel_a || wake_sel_b)) || ext_fail || sys_on_rc) |=> reg_rdata[0]);

    p_keep_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && reg_rdata[1]) |-> rc_osc_en);

    p_rc_rdy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && !reg_rdata[2]) |=> !reg_rdata[2]);

    p_rc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] && !reg_rdata[0] && !rc_tick) |=> reg_rdata[2]);

    p_ext_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_on_ext && reg_rdata[3] && !lp_enter) |=> reg_rdata[3]);

    p_lp_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter |=> (!reg_rdata[3] && !reg_rdata[7]));

    p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !reg_rdata[3] && !ext_tick) |=> reg_rdata[4]);

    p_byp_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |=> $stable(reg_rdata[5]));

    p_sec_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] |=> reg_rdata[6]);

    p_sec_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wr_sec) |=> reg_rdata[6]);

    p_det_needs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_det_en |-> (reg_rdata[6] && reg_rdata[4]));

    p_det_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fail |=> !clk_det_en);

    p_pll_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_on_pll && reg_rdata[7] && !lp_enter) |=> reg_rdata[7]);

    p_lock_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pll_lock |=> reg_rdata[8]);

    p_lock_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |=> !reg_rdata[8]);
endmodule

bind clk_ctrl_reg clk_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_sec(reg_wdata[6]),
    .reg_rdata(reg_rdata), .lp_enter(lp_enter), .in_stop(in_stop),
    .stop_exit(stop_exit), .wake_sel_a(wake_sel_a), .wake_sel_b(wake_sel_b),
    .ext_fail(ext_fail), .sys_on_rc(sys_on_rc), .sys_on_ext(sys_on_ext),
    .sys_on_pll(sys_on_pll), .pll_lock(pll_lock), .rc_tick(rc_tick),
    .ext_tick(ext_tick), .rc_osc_en(rc_osc_en), .clk_det_en(clk_det_en)
);

// File: tb/tb_clk_ctrl_reg.sv
`timescale 1ns/1ps
module tb_clk_ctrl_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic lp_enter = 0, in_stop = 0, stop_exit = 0, wake_sel_a = 0, wake_sel_b = 0;
    logic ext_fail = 0, sys_on_rc = 0, sys_on_ext = 0, sys_on_pll = 0;
    logic rc_stable = 0, ext_stable = 0, pll_lock = 0, rc_tick = 0, ext_tick = 0;
    logic rc_osc_en, ext_osc_en, ext_bypass, pll_en, clk_det_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    clk_ctrl_reg dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lp_enter(lp_enter), .in_stop(in_stop),
        .stop_exit(stop_exit), .wake_sel_a(wake_sel_a), .wake_sel_b(wake_sel_b),
        .ext_fail(ext_fail), .sys_on_rc(sys_on_rc), .sys_on_ext(sys_on_ext),
        .sys_on_pll(sys_on_pll), .rc_stable(rc_stable), .ext_stable(ext_stable),
        .pll_lock(pll_lock), .rc_tick(rc_tick), .ext_tick(ext_tick),
        .rc_osc_en(rc_osc_en), .ext_osc_en(ext_osc_en), .ext_bypass(ext_bypass),
        .pll_en(pll_en), .clk_det_en(clk_det_en)
    );

    // Reference model built from the requirements
    logic m_rc_en, m_keep, m_ext_en, m_byp, m_sec, m_pll_en, m_pll_rdy, m_fail;
    logic m_rc_rdy, m_ext_rdy;
    int   m_rc_cnt, m_ext_cnt;

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[0] = m_rc_en;  w[1] = m_keep;   w[2] = m_rc_rdy;
        w[3] = m_ext_en; w[4] = m_ext_rdy; w[5] = m_byp;
        w[6] = m_sec;    w[7] = m_pll_en;  w[8] = m_pll_rdy;
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_rc_en, m_keep, m_ext_en, m_byp, m_sec, m_pll_en, m_pll_rdy, m_fail} = '0;
            m_rc_rdy = 0; m_ext_rdy = 0; m_rc_cnt = 0; m_ext_cnt = 0;
        end else begin
            logic n_rc_en, n_keep, n_ext_en, n_byp, n_sec, n_pll_en, n_fail;
            logic was_ext_en;
            n_rc_en = m_rc_en; n_keep = m_keep; n_ext_en = m_ext_en; n_byp = m_byp;
            n_sec = m_sec; n_pll_en = m_pll_en; n_fail = m_fail;
            was_ext_en = m_ext_en;
            if (reg_wr) begin
                n_rc_en = reg_wdata[0];
                n_keep  = reg_wdata[1];
                if (reg_wdata[3]) n_ext_en = 1; else if (!sys_on_ext) n_ext_en = 0;
                if (reg_wdata[7]) n_pll_en = 1; else if (!sys_on_pll) n_pll_en = 0;
                if (reg_wdata[6]) n_sec = 1;
                if (!m_ext_en) n_byp = reg_wdata[5];
            end
            if (lp_enter) begin n_rc_en = 0; n_ext_en = 0; n_pll_en = 0; end
            if (sys_on_rc || ext_fail || (stop_exit && (wake_sel_a || wake_sel_b))) n_rc_en = 1;
            if (ext_fail) n_fail = 1; else if (!was_ext_en) n_fail = 0;
            // ready flags: drain counts from the state before this edge
            if (m_rc_en) begin m_rc_rdy = rc_stable; m_rc_cnt = 0; end
            else if (m_rc_rdy) begin
                if (rc_tick) begin
                    m_rc_cnt++;
                    if (m_rc_cnt == 6) begin m_rc_rdy = 0; m_rc_cnt = 0; end
                end
            end else m_rc_cnt = 0;
            if (m_ext_en) begin m_ext_rdy = ext_stable; m_ext_cnt = 0; end
            else if (m_ext_rdy) begin
                if (ext_tick) begin
                    m_ext_cnt++;
                    if (m_ext_cnt == 6) begin m_ext_rdy = 0; m_ext_cnt = 0; end
                end
            end else m_ext_cnt = 0;
            m_pll_rdy = pll_lock;
            m_rc_en = n_rc_en; m_keep = n_keep; m_ext_en = n_ext_en; m_byp = n_byp;
            m_sec = n_sec; m_pll_en = n_pll_en; m_fail = n_fail;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h @%0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R1 R2 R4 R5 R6 R7 R8 R9 R11 R12 R13 word vs model", reg_rdata, model_word());
            chk("R3 R8 R10 outputs vs model",
                {27'd0, rc_osc_en, ext_osc_en, ext_bypass, pll_en, clk_det_en},
                {27'd0, m_rc_en | (m_keep & in_stop), m_ext_en, m_byp, m_pll_en,
                 m_sec & m_ext_rdy & ~m_fail});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d;
        step(1);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rc_ticks(input int n);
        rc_tick = 1; step(n); rc_tick = 0;
    endtask

    task automatic ext_ticks(input int n);
        ext_tick = 1; step(n); ext_tick = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0C1C);
        rc_stable = 1;
        step(3);
        rst_n = 1;
        step(1);
        cmp_on = 1;
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R4 no ready without enable", {31'd0, reg_rdata[2]}, 32'd0);

        // R4/R5 RC ready rise and six-tick drain
        wr(32'h1);
        step(1);
        chk("R4 rc ready set", reg_rdata, 32'h5);
        wr(32'h0);
        for (int i = 0; i < 5; i++) begin rc_tick = 1; step(1); rc_tick = 0; step(1); end
        chk("R5 rc ready held after 5 ticks", {31'd0, reg_rdata[2]}, 32'd1);
        rc_ticks(1);
        chk("R5 rc ready drop on 6th tick", {31'd0, reg_rdata[2]}, 32'd0);

        // R7/R8 external ready and bypass lock
        ext_stable = 1;
        wr(32'h8);
        step(1);
        chk("R7 ext ready set", reg_rdata, 32'h18);
        wr(32'h28);
        chk("R8 bypass ignored while enabled", {31'd0, reg_rdata[5]}, 32'd0);
        wr(32'h0);
        ext_ticks(5);
        chk("R7 ext ready held after 5 ticks", {31'd0, reg_rdata[4]}, 32'd1);
        ext_ticks(1);
        chk("R7 ext ready drop on 6th tick", {31'd0, reg_rdata[4]}, 32'd0);
        wr(32'h20);
        chk("R8 bypass accepted while disabled", {31'd0, reg_rdata[5]}, 32'd1);
        wr(32'h0);
        chk("R8 bypass cleared while disabled", {31'd0, ext_bypass}, 32'd0);

        // R9 set-only security enable
        wr(32'h40);
        wr(32'h0);
        chk("R9 security ignores write 0", {31'd0, reg_rdata[6]}, 32'd1);

        // R10 clock detector and failure
        wr(32'h8);
        step(1);
        chk("R10 detector on", {31'd0, clk_det_en}, 32'd1);
        ext_fail = 1; step(1); ext_fail = 0;
        chk("R10 detector off after failure", {31'd0, clk_det_en}, 32'd0);
        chk("R2 failure forces rc enable", {31'd0, reg_rdata[0]}, 32'd1);
        step(2);
        chk("R10 detector stays off", {31'd0, clk_det_en}, 32'd0);
        wr(32'h0);
        ext_ticks(6);
        rc_ticks(6);

        // R6 external enable protection and low-power clear
        sys_on_ext = 1;
        wr(32'h8);
        wr(32'h0);
        chk("R6 protected ext enable", {31'd0, reg_rdata[3]}, 32'd1);
        lp_enter = 1; step(1); lp_enter = 0;
        chk("R6 lp clears ext enable", {31'd0, reg_rdata[3]}, 32'd0);
        sys_on_ext = 0;
        ext_ticks(6);

        // R2 forced sets
        stop_exit = 1; step(1); stop_exit = 0;
        chk("R2 plain stop exit no force", {31'd0, reg_rdata[0]}, 32'd0);
        stop_exit = 1; wake_sel_b = 1; step(1); stop_exit = 0; wake_sel_b = 0;
        chk("R2 wake select forces rc enable", {31'd0, reg_rdata[0]}, 32'd1);
        wr(32'h0);
        chk("R2 software clears rc enable", {31'd0, reg_rdata[0]}, 32'd0);
        sys_on_rc = 1;
        wr(32'h0);
        chk("R2 system clock keeps rc enable", {31'd0, reg_rdata[0]}, 32'd1);
        lp_enter = 1; step(1); lp_enter = 0;
        chk("R2 force wins over lp entry", {31'd0, reg_rdata[0]}, 32'd1);
        sys_on_rc = 0;
        wr(32'h0);
        rc_ticks(6);

        // R3 keep-in-stop
        in_stop = 1;
        wr(32'h2);
        chk("R3 keep bit leaves rc enable", reg_rdata[1:0], 2'b10);
        chk("R3 keep runs rc in stop", {31'd0, rc_osc_en}, 32'd1);
        in_stop = 0; #1;
        chk("R3 no run outside stop", {31'd0, rc_osc_en}, 32'd0);
        wr(32'h0);

        // R11 PLL protection
        sys_on_pll = 1;
        wr(32'h80);
        wr(32'h0);
        chk("R11 protected pll enable", {31'd0, reg_rdata[7]}, 32'd1);
        lp_enter = 1; step(1); lp_enter = 0;
        chk("R11 lp clears pll enable", {31'd0, reg_rdata[7]}, 32'd0);
        sys_on_pll = 0;

        // R12 lock mirror
        pll_lock = 1; step(1);
        chk("R12 lock high", {31'd0, reg_rdata[8]}, 32'd1);
        pll_lock = 0; step(1);
        chk("R12 lock low", {31'd0, reg_rdata[8]}, 32'd0);

        // R13 read-only bits
        wr(32'hFFFF_FF14);
        chk("R13 ready and upper bits ignore writes",
            reg_rdata & 32'hFFFF_FF14, 32'h0000_0000);
        wr(32'h0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            reg_wr     = ($urandom_range(2) == 0);
            reg_wdata  = $urandom;
            lp_enter   = ($urandom_range(19) == 0);
            stop_exit  = ($urandom_range(15) == 0);
            wake_sel_a = $urandom_range(1);
            wake_sel_b = ($urandom_range(3) == 0);
            ext_fail   = ($urandom_range(39) == 0);
            in_stop    = $urandom_range(1);
            rc_tick    = $urandom_range(1);
            ext_tick   = $urandom_range(1);
            if ($urandom_range(63) == 0) sys_on_rc  = ~sys_on_rc;
            if ($urandom_range(63) == 0) sys_on_ext = ~sys_on_ext;
            if ($urandom_range(63) == 0) sys_on_pll = ~sys_on_pll;
            if ($urandom_range(7) == 0)  rc_stable  = ~rc_stable;
            if ($urandom_range(7) == 0)  ext_stable = ~ext_stable;
            if ($urandom_range(5) == 0)  pll_lock   = ~pll_lock;
            step(1);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule